// File: doc/BRIEF.md
# Non-intrusive processor debug port

This block sits beside a processor core and gives an external debug host control over it. The host has an 8-bit command input, a 32-bit operand input, a 32-bit result output and a 14-bit status word. While the core runs, the port leaves its address flow and timing untouched. The only exception is a breakpoint hit, which holds back the matching instruction. The host can stop, run and single-step the core. While the core is halted, the host can inspect and change core registers, memory and I/O. It can also arm address breakpoints and stream a trace of retired instructions.

The core presents the address of the instruction that will retire next (`core_pc_i`) and a retire request. The port answers with a stall. An instruction retires in a cycle where the request is high and the stall is low. Register and memory accesses use a one-cycle strobe. Read data is expected on the cycle after the strobe. The result output is shared: it shows the read value in the cycle a read completes, and it carries trace words at all other times.

Top module: `dbg_port`

## Requirements
- R1: Status bit 0 (ready) is high only when the port is idle. A command is taken when `cmd_valid_i` is high while ready is high. Ready then stays low until status bit 1 (done) has been high for one cycle, and it is high again in the cycle after done.
- R2: Command codes are: 0x01 run, 0x02 stop, 0x03 step, 0x10 register read, 0x11 register write, 0x20 memory read, 0x21 memory write, 0x22 I/O read, 0x23 I/O write, 0x30 breakpoint set, 0x31 breakpoint clear, 0x40 trace on, 0x41 trace off, 0xFF debug reset. Any other code completes with status bit 2 (error) high in its done cycle.
- R3: For register commands, the operand word is the register number. A write takes its value from the next `data_valid_i` word. A read drives the fetched value on `data_o` in its done cycle.
- R4: Memory and I/O commands use the operand word as the address. `mem_io_o` is high for the I/O codes, so the two are separate spaces. Writes and reads otherwise behave as in R3.
- R5: A register, memory or I/O command issued while the core is not halted completes with error and raises no access strobe.
- R6: Status bits [4:3] give the core state: 00 running, 01 halted, 10 stepping. After reset the core is halted. While halted, the stall is held and no instruction retires. Run and stop set the state.
- R7: Step lets exactly one instruction retire, even one sitting on a breakpoint, and then the core is halted.
- R8: There are NUM_BP address comparators. Breakpoint set takes its index from operand bits [3:0] and its address from the next data word. An index of NUM_BP or above gives an error. While running, an instruction whose address matches is stalled and does not retire. The core halts, status bit 7 (hit) goes high, and bits [11:8] give the lowest matching index. Run and step clear the hit bit.
- R9: Breakpoint clear (index in operand bits [3:0]) disarms that comparator, so execution no longer stops at its address.
- R10: While trace is enabled (status bit 12), each retired instruction produces a two-word packet on `data_o`. The first word is its address, with status bit 6 (first word) high. The second word is a free-running cycle count taken at retirement. Bit 5 marks a valid trace word. With trace off, no packets are produced.
- R11: Status bit 13 (trace lost) goes high and stays high when an instruction retires while the packet buffer is full. The next trace-on command clears it.
- R12: Debug reset disarms all comparators, turns trace off, clears the hit and lost bits, empties the packet buffer and halts the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 8 | Command code |
| data_valid_i | input | 1 | Write-value strobe |
| data_i | input | 32 | Operand or write value |
| data_o | output | 32 | Read result or trace word |
| status_o | output | 14 | Status word |
| core_pc_i | input | 32 | Address of next instruction to retire |
| core_retire_i | input | 1 | Core wants to retire an instruction |
| core_stall_o | output | 1 | Holds back retirement |
| reg_addr_o | output | 32 | Register number |
| reg_wdata_o | output | 32 | Register write value |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 32 | Register read value, one cycle after strobe |
| mem_addr_o | output | 32 | Memory or I/O address |
| mem_wdata_o | output | 32 | Memory or I/O write value |
| mem_we_o | output | 1 | Memory or I/O write strobe |
| mem_re_o | output | 1 | Memory or I/O read strobe |
| mem_io_o | output | 1 | Access targets I/O space |
| mem_rdata_i | input | 32 | Memory or I/O read value, one cycle after strobe |

## Verification
The bench builds the port with NUM_BP = 4 and TRACE_DEPTH = 2. With four comparators, every index and an out-of-range index can each be armed, hit and cleared. The two-packet buffer can be overrun by back-to-back retirement, yet it keeps pace with a retirement every other cycle. The bench also sends every one of the 256 command codes and walks all 8 modelled registers and all 16 memory and I/O words. Trace address and timestamp deltas are checked arithmetically against the retirement pattern.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam logic [7:0] CMD_RUN     = 8'h01;
  localparam logic [7:0] CMD_STOP    = 8'h02;
  localparam logic [7:0] CMD_STEP    = 8'h03;
  localparam logic [7:0] CMD_REG_RD  = 8'h10;
  localparam logic [7:0] CMD_REG_WR  = 8'h11;
  localparam logic [7:0] CMD_MEM_RD  = 8'h20;
  localparam logic [7:0] CMD_MEM_WR  = 8'h21;
  localparam logic [7:0] CMD_IO_RD   = 8'h22;
  localparam logic [7:0] CMD_IO_WR   = 8'h23;
  localparam logic [7:0] CMD_BP_SET  = 8'h30;
  localparam logic [7:0] CMD_BP_CLR  = 8'h31;
  localparam logic [7:0] CMD_TRC_ON  = 8'h40;
  localparam logic [7:0] CMD_TRC_OFF = 8'h41;
  localparam logic [7:0] CMD_DBG_RST = 8'hFF;

  typedef enum logic [1:0] {CS_RUN = 2'b00, CS_HALT = 2'b01, CS_STEP = 2'b10} core_st_e;
  typedef enum logic [2:0] {F_IDLE, F_WAIT, F_EXEC, F_CAP, F_DONE} fsm_e;
endpackage

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit #(
  parameter int NUM_BP = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        set_i,
  input  logic        clr_i,
  input  logic        clr_all_i,
  input  logic [3:0]  idx_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] pc_i,
  output logic        match_o,
  output logic [3:0]  match_idx_o
);
  logic [NUM_BP-1:0] hit;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
    logic        vld_q;
    logic [31:0] adr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        adr_q <= '0;
      end else if (clr_all_i || (clr_i && idx_i == 4'(g))) begin
        vld_q <= 1'b0;
      end else if (set_i && idx_i == 4'(g)) begin
        vld_q <= 1'b1;
        adr_q <= addr_i;
      end
    end
    assign hit[g] = vld_q && (adr_q == pc_i);
  end

  // lowest index wins
  always_comb begin
    match_idx_o = '0;
    for (int i = NUM_BP - 1; i >= 0; i--)
      if (hit[i]) match_idx_o = 4'(i);
  end
  assign match_o = |hit;
endmodule

// File: rtl/dbg_trace.sv
module dbg_trace #(
  parameter int DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic        lost_clr_i,
  input  logic        push_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] ts_i,
  input  logic        hold_i,
  output logic        valid_o,
  output logic        first_o,
  output logic [31:0] word_o,
  output logic        lost_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0] pc_q [DEPTH];
  logic [31:0] ts_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [PW:0]   cnt_q;
  logic          phase_q, lost_q;
  logic          full, adv, pop, put;

  assign full = (cnt_q == (PW+1)'(DEPTH));
  assign adv  = (cnt_q != '0) && !hold_i;
  assign pop  = adv && phase_q;
  assign put  = push_i && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0; phase_q <= 1'b0; lost_q <= 1'b0;
    end else if (flush_i) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0; phase_q <= 1'b0; lost_q <= 1'b0;
    end else begin
      if (put) begin
        pc_q[wr_q] <= pc_i;
        ts_q[wr_q] <= ts_i;
        wr_q <= wr_q + 1'b1;
      end
      if (adv) phase_q <= ~phase_q;
      if (pop) rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(put) - (PW+1)'(pop);
      if (lost_clr_i) lost_q <= 1'b0;
      else if (push_i && full) lost_q <= 1'b1;
    end
  end

  assign valid_o = adv;
  assign first_o = adv && !phase_q;
  assign word_o  = phase_q ? ts_q[rd_q] : pc_q[rd_q];
  assign lost_o  = lost_q;
endmodule

// File: rtl/dbg_port.sv
module dbg_port
  import dbg_pkg::*;
#(
  parameter int NUM_BP      = 16,
  parameter int TRACE_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [7:0]  cmd_i,
  input  logic        data_valid_i,
  input  logic [31:0] data_i,
  output logic [31:0] data_o,
  output logic [13:0] status_o,
  input  logic [31:0] core_pc_i,
  input  logic        core_retire_i,
  output logic        core_stall_o,
  output logic [31:0] reg_addr_o,
  output logic [31:0] reg_wdata_o,
  output logic        reg_we_o,
  output logic        reg_re_o,
  input  logic [31:0] reg_rdata_i,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic        mem_we_o,
  output logic        mem_re_o,
  output logic        mem_io_o,
  input  logic [31:0] mem_rdata_i
);
  fsm_e        fsm_q;
  core_st_e    cs_q;
  logic [7:0]  cmd_q;
  logic [31:0] opnd_q, wval_q, rdat_q, ts_q;
  logic        err_q, rd_show_q, trc_en_q, hit_q;
  logic [3:0]  hit_idx_q;
  logic        accept, halted, bp_match, retire, is_rd, is_reg, hold;
  logic [3:0]  bp_idx, match_idx;
  logic        trc_v, trc_f, trc_lost;
  logic [31:0] trc_w;

  assign accept = (fsm_q == F_IDLE) && cmd_valid_i;
  assign halted = (cs_q == CS_HALT);
  assign is_rd  = (cmd_q == CMD_REG_RD) || (cmd_q == CMD_MEM_RD) || (cmd_q == CMD_IO_RD);
  assign is_reg = (cmd_q == CMD_REG_RD) || (cmd_q == CMD_REG_WR);
  assign core_stall_o = halted || ((cs_q == CS_RUN) && bp_match);
  assign retire = core_retire_i && !core_stall_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q <= F_IDLE; cs_q <= CS_HALT; cmd_q <= '0; opnd_q <= '0; wval_q <= '0;
      rdat_q <= '0; err_q <= 1'b0; rd_show_q <= 1'b0; trc_en_q <= 1'b0;
      hit_q <= 1'b0; hit_idx_q <= '0;
    end else begin
      // core-side transitions; a command accepted in the same cycle overrides
      if (cs_q == CS_RUN && core_retire_i && bp_match) begin
        cs_q <= CS_HALT; hit_q <= 1'b1; hit_idx_q <= match_idx;
      end else if (cs_q == CS_STEP && core_retire_i) begin
        cs_q <= CS_HALT;
      end
      unique case (fsm_q)
        F_IDLE: if (cmd_valid_i) begin
          cmd_q <= cmd_i; opnd_q <= data_i; err_q <= 1'b0; rd_show_q <= 1'b0;
          fsm_q <= F_DONE;
          case (cmd_i)
            CMD_RUN:  begin cs_q <= CS_RUN;  hit_q <= 1'b0; hit_idx_q <= '0; end
            CMD_STOP: cs_q <= CS_HALT;
            CMD_STEP: begin cs_q <= CS_STEP; hit_q <= 1'b0; hit_idx_q <= '0; end
            CMD_REG_RD, CMD_MEM_RD, CMD_IO_RD:
              if (halted) fsm_q <= F_EXEC; else err_q <= 1'b1;
            CMD_REG_WR, CMD_MEM_WR, CMD_IO_WR:
              if (halted) fsm_q <= F_WAIT; else err_q <= 1'b1;
            CMD_BP_SET:
              if (32'(data_i[3:0]) < NUM_BP) fsm_q <= F_WAIT; else err_q <= 1'b1;
            CMD_BP_CLR: err_q <= !(32'(data_i[3:0]) < NUM_BP);
            CMD_TRC_ON:  trc_en_q <= 1'b1;
            CMD_TRC_OFF: trc_en_q <= 1'b0;
            CMD_DBG_RST: begin
              cs_q <= CS_HALT; trc_en_q <= 1'b0; hit_q <= 1'b0; hit_idx_q <= '0;
            end
            default: err_q <= 1'b1;
          endcase
        end
        F_WAIT: if (data_valid_i) begin
          wval_q <= data_i;
          fsm_q  <= (cmd_q == CMD_BP_SET) ? F_DONE : F_EXEC;
        end
        F_EXEC: fsm_q <= is_rd ? F_CAP : F_DONE;
        F_CAP: begin
          rdat_q    <= is_reg ? reg_rdata_i : mem_rdata_i;
          rd_show_q <= 1'b1;
          fsm_q     <= F_DONE;
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + 32'd1;
  end

  assign reg_addr_o  = opnd_q;
  assign reg_wdata_o = wval_q;
  assign mem_addr_o  = opnd_q;
  assign mem_wdata_o = wval_q;
  assign reg_we_o = (fsm_q == F_EXEC) && (cmd_q == CMD_REG_WR);
  assign reg_re_o = (fsm_q == F_EXEC) && (cmd_q == CMD_REG_RD);
  assign mem_we_o = (fsm_q == F_EXEC) && ((cmd_q == CMD_MEM_WR) || (cmd_q == CMD_IO_WR));
  assign mem_re_o = (fsm_q == F_EXEC) && ((cmd_q == CMD_MEM_RD) || (cmd_q == CMD_IO_RD));
  assign mem_io_o = (cmd_q == CMD_IO_RD) || (cmd_q == CMD_IO_WR);

  assign bp_idx = (fsm_q == F_IDLE) ? data_i[3:0] : opnd_q[3:0];

  dbg_bp_unit #(.NUM_BP(NUM_BP)) u_bp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       ((fsm_q == F_WAIT) && data_valid_i && (cmd_q == CMD_BP_SET)),
    .clr_i       (accept && (cmd_i == CMD_BP_CLR)),
    .clr_all_i   (accept && (cmd_i == CMD_DBG_RST)),
    .idx_i       (bp_idx),
    .addr_i      (data_i),
    .pc_i        (core_pc_i),
    .match_o     (bp_match),
    .match_idx_o (match_idx)
  );

  assign hold = (fsm_q == F_DONE) && rd_show_q;

  dbg_trace #(.DEPTH(TRACE_DEPTH)) u_trc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (accept && (cmd_i == CMD_DBG_RST)),
    .lost_clr_i (accept && (cmd_i == CMD_TRC_ON)),
    .push_i     (retire && trc_en_q),
    .pc_i       (core_pc_i),
    .ts_i       (ts_q),
    .hold_i     (hold),
    .valid_o    (trc_v),
    .first_o    (trc_f),
    .word_o     (trc_w),
    .lost_o     (trc_lost)
  );

  assign data_o = hold ? rdat_q : trc_w;
  assign status_o = {trc_lost, trc_en_q, hit_idx_q, hit_q, trc_f, trc_v,
                     cs_q, (fsm_q == F_DONE) && err_q, (fsm_q == F_DONE), (fsm_q == F_IDLE)};
endmodule

// File: rtl/dbg_port_chk.sv
module dbg_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       rdy_i,
  input logic       done_i,
  input logic [1:0] cs_i,
  input logic       tv_i,
  input logic       tf_i,
  input logic       hit_i,
  input logic       core_retire_i,
  input logic       core_stall_o,
  input logic       acc_i
);
  logic take;
  assign take = cmd_valid_i && rdy_i;

  assert_accept_drops_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !rdy_i);
  assert_done_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!done_i && rdy_i));
  assert_no_access_running_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> (cs_i == 2'b01));
  assert_halt_stalls_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i == 2'b01) |-> core_stall_o);
  assert_step_halts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i == 2'b10 && core_retire_i && !take) |=> (cs_i == 2'b01));
  assert_bp_halts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i == 2'b00 && core_retire_i && core_stall_o && !take) |=> (cs_i == 2'b01 && hit_i));
  assert_first_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_i |-> tv_i);
  assert_two_words_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_i |=> !tf_i);
endmodule

bind dbg_port dbg_port_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_i   (cmd_valid_i),
  .rdy_i         (status_o[0]),
  .done_i        (status_o[1]),
  .cs_i          (status_o[4:3]),
  .tv_i          (status_o[5]),
  .tf_i          (status_o[6]),
  .hit_i         (status_o[7]),
  .core_retire_i (core_retire_i),
  .core_stall_o  (core_stall_o),
  .acc_i         (reg_we_o || reg_re_o || mem_we_o || mem_re_o)
);

// File: tb/sim_dbg_port.sv
module sim_dbg_port;
  localparam int CLK_PERIOD = 10;
  localparam int NBP = 4;
  localparam int TDEPTH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, data_valid = 1'b0;
  logic [7:0]  cmd = '0;
  logic [31:0] din = '0, dout;
  logic [13:0] st;
  logic [31:0] pc, reg_addr, reg_wdata, mem_addr, mem_wdata;
  logic [31:0] reg_rdata = '0, mem_rdata = '0;
  logic stall, reg_we, reg_re, mem_we, mem_re, mem_io, want;
  int mode = 0;
  logic ph;
  int n_chk = 0, n_fail = 0, strobes = 0;
  logic [31:0] rf [8];
  logic [31:0] mm [16];
  logic [31:0] io [16];
  logic [31:0] tw [64];
  logic        tfl [64];
  int tn = 0;
  bit mon_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign want = (mode == 1) || (mode == 2 && ph);

  dbg_port #(.NUM_BP(NBP), .TRACE_DEPTH(TDEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .data_valid_i(data_valid), .data_i(din), .data_o(dout), .status_o(st),
    .core_pc_i(pc), .core_retire_i(want), .core_stall_o(stall),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_re_o(reg_re),
    .reg_rdata_i(reg_rdata), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_io_o(mem_io), .mem_rdata_i(mem_rdata)
  );

  // core, register file and memory models
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= 32'h100; ph <= 1'b0;
    end else begin
      ph <= ~ph;
      if (want && !stall) pc <= pc + 32'd4;
      if (reg_re) reg_rdata <= rf[reg_addr[2:0]];
      if (reg_we) rf[reg_addr[2:0]] <= reg_wdata;
      if (mem_re) mem_rdata <= mem_io ? io[mem_addr[3:0]] : mm[mem_addr[3:0]];
      if (mem_we && mem_io)  io[mem_addr[3:0]] <= mem_wdata;
      if (mem_we && !mem_io) mm[mem_addr[3:0]] <= mem_wdata;
      if (reg_we || reg_re || mem_we || mem_re) strobes <= strobes + 1;
    end
  end

  always @(negedge clk)
    if (mon_en && st[5] && tn < 64) begin
      tw[tn] = dout; tfl[tn] = st[6]; tn = tn + 1;
    end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_cmd(input logic [7:0] c, input logic [31:0] op, input bit has_wr,
                        input logic [31:0] wv, output bit err, output logic [31:0] rd);
    int k = 0;
    while (!st[0] && k < 20) begin tick(); k++; end
    cmd_valid = 1'b1; cmd = c; din = op;
    tick();
    cmd_valid = 1'b0;
    chk("R1", "ready low after accept", {31'b0, st[0]}, 32'd0);
    if (has_wr && !st[1]) begin
      data_valid = 1'b1; din = wv;
      tick();
      data_valid = 1'b0;
    end
    k = 0;
    while (!st[1] && k < 20) begin tick(); k++; end
    err = st[2]; rd = dout;
    chk("R1", "done seen", {31'b0, st[1]}, 32'd1);
    tick();
    chk("R1", "done one cycle then ready", {30'b0, st[1], st[0]}, 32'd1);
  endtask

  function automatic bit known(input int c);
    return c == 8'h01 || c == 8'h02 || c == 8'h03 || c == 8'h10 || c == 8'h11 ||
           c == 8'h20 || c == 8'h21 || c == 8'h22 || c == 8'h23 || c == 8'h30 ||
           c == 8'h31 || c == 8'h40 || c == 8'h41 || c == 8'hFF;
  endfunction

  task automatic wait_halt();
    int k = 0;
    while (st[4:3] != 2'b01 && k < 80) begin tick(); k++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bit e;
    logic [31:0] r, p0, a;
    int s0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R6 R1 reset state
    chk("R1", "reset ready", {31'b0, st[0]}, 32'd1);
    chk("R1", "reset done", {31'b0, st[1]}, 32'd0);
    chk("R6", "reset halted", {30'b0, st[4:3]}, 32'd1);
    chk("R6", "reset stall", {31'b0, stall}, 32'd1);
    chk("R10", "reset trace idle", {18'b0, st[13:0] & 14'h3060}, 32'd0);

    // R2 every unknown code errors, known simple codes do not
    for (int c = 0; c < 256; c++)
      if (!known(c)) begin
        do_cmd(8'(c), 32'd0, 1'b0, 32'd0, e, r);
        chk("R2", $sformatf("unknown %02h", c), {31'b0, e}, 32'd1);
      end
    do_cmd(8'h02, 32'd0, 1'b0, 32'd0, e, r);
    chk("R2", "stop no error", {31'b0, e}, 32'd0);

    // R3 register round trip
    for (int i = 0; i < 8; i++) begin
      do_cmd(8'h11, 32'(i), 1'b1, 32'h5A00_0000 + 32'(i) * 32'h0101_0101, e, r);
      chk("R3", "reg write ok", {31'b0, e}, 32'd0);
    end
    for (int i = 0; i < 8; i++) begin
      do_cmd(8'h10, 32'(i), 1'b0, 32'd0, e, r);
      chk("R3", $sformatf("reg %0d read", i), r, 32'h5A00_0000 + 32'(i) * 32'h0101_0101);
    end

    // R4 memory and I/O are separate spaces
    for (int i = 0; i < 16; i++) begin
      do_cmd(8'h21, 32'(i), 1'b1, 32'hC000_0000 | (32'(i) * 3), e, r);
      do_cmd(8'h23, 32'(i), 1'b1, 32'h0D00_0000 | (32'(i) * 7), e, r);
    end
    for (int i = 0; i < 16; i++) begin
      do_cmd(8'h20, 32'(i), 1'b0, 32'd0, e, r);
      chk("R4", $sformatf("mem %0d", i), r, 32'hC000_0000 | (32'(i) * 3));
      do_cmd(8'h22, 32'(i), 1'b0, 32'd0, e, r);
      chk("R4", $sformatf("io %0d", i), r, 32'h0D00_0000 | (32'(i) * 7));
    end

    // R6 run, R5 access refused while running
    mode = 0;
    do_cmd(8'h01, 32'd0, 1'b0, 32'd0, e, r);
    chk("R6", "running state", {30'b0, st[4:3]}, 32'd0);
    s0 = strobes;
    do_cmd(8'h11, 32'd2, 1'b1, 32'hDEAD_BEEF, e, r);
    chk("R5", "reg write while running", {31'b0, e}, 32'd1);
    do_cmd(8'h20, 32'd1, 1'b0, 32'd0, e, r);
    chk("R5", "mem read while running", {31'b0, e}, 32'd1);
    do_cmd(8'h23, 32'd1, 1'b1, 32'h1234, e, r);
    chk("R5", "io write while running", {31'b0, e}, 32'd1);
    chk("R5", "no strobes while running", 32'(strobes - s0), 32'd0);
    do_cmd(8'h02, 32'd0, 1'b0, 32'd0, e, r);
    chk("R6", "stopped", {30'b0, st[4:3]}, 32'd1);
    do_cmd(8'h10, 32'd2, 1'b0, 32'd0, e, r);
    chk("R5", "reg 2 untouched", r, 32'h5A00_0000 + 32'd2 * 32'h0101_0101);

    // R6 halted core does not retire
    mode = 1; p0 = pc;
    repeat (6) tick();
    chk("R6", "pc frozen while halted", pc, p0);

    // R7 step retires exactly one
    for (int i = 0; i < 3; i++) begin
      p0 = pc;
      do_cmd(8'h03, 32'd0, 1'b0, 32'd0, e, r);
      repeat (4) tick();
      chk("R7", "step advances one", pc, p0 + 32'd4);
      chk("R7", "halted after step", {30'b0, st[4:3]}, 32'd1);
    end

    // R8 R9 each comparator
    for (int i = 0; i < NBP; i++) begin
      mode = 0;
      a = pc + 32'd8 * 32'(i + 1);
      do_cmd(8'h30, 32'(i), 1'b1, a, e, r);
      chk("R8", "bp set ok", {31'b0, e}, 32'd0);
      mode = 1;
      do_cmd(8'h01, 32'd0, 1'b0, 32'd0, e, r);
      wait_halt();
      chk("R8", $sformatf("bp %0d stop pc", i), pc, a);
      chk("R8", $sformatf("bp %0d hit/idx", i), {27'b0, st[11:7]}, {27'b0, 4'(i), 1'b1});
      p0 = pc;
      do_cmd(8'h03, 32'd0, 1'b0, 32'd0, e, r);
      repeat (3) tick();
      chk("R7", "step past bp", pc, p0 + 32'd4);
      chk("R7", "step clears hit", {31'b0, st[7]}, 32'd0);
      mode = 0;
      a = pc + 32'd16;
      do_cmd(8'h30, 32'(i), 1'b1, a, e, r);
      do_cmd(8'h31, 32'(i), 1'b0, 32'd0, e, r);
      chk("R9", "bp clear ok", {31'b0, e}, 32'd0);
      mode = 1;
      do_cmd(8'h01, 32'd0, 1'b0, 32'd0, e, r);
      repeat (10) tick();
      chk("R9", "cleared bp passes", {31'b0, (pc > a)}, 32'd1);
      chk("R9", "still running", {29'b0, st[7], st[4:3]}, 32'd0);
      mode = 0;
      do_cmd(8'h02, 32'd0, 1'b0, 32'd0, e, r);
    end
    do_cmd(8'h30, 32'd5, 1'b1, 32'h0, e, r);
    chk("R8", "bp index out of range", {31'b0, e}, 32'd1);
    do_cmd(8'h31, 32'd9, 1'b0, 32'd0, e, r);
    chk("R9", "clear index out of range", {31'b0, e}, 32'd1);

    // R8 priority: lowest index on a shared address
    a = pc + 32'd12;
    do_cmd(8'h30, 32'd3, 1'b1, a, e, r);
    do_cmd(8'h30, 32'd1, 1'b1, a, e, r);
    mode = 1;
    do_cmd(8'h01, 32'd0, 1'b0, 32'd0, e, r);
    wait_halt();
    chk("R8", "priority stop pc", pc, a);
    chk("R8", "priority idx", {28'b0, st[11:8]}, 32'd1);

    // R12 debug reset drops breakpoints
    mode = 0;
    do_cmd(8'h03, 32'd0, 1'b0, 32'd0, e, r);
    a = pc + 32'd8;
    do_cmd(8'h30, 32'd0, 1'b1, a, e, r);
    do_cmd(8'h40, 32'd0, 1'b0, 32'd0, e, r);
    do_cmd(8'h01, 32'd0, 1'b0, 32'd0, e, r);
    do_cmd(8'hFF, 32'd0, 1'b0, 32'd0, e, r);
    chk("R12", "halted, trace off, no hit", {18'b0, st & 14'h3198}, 32'h8);
    mode = 1; p0 = pc;
    do_cmd(8'h01, 32'd0, 1'b0, 32'd0, e, r);
    repeat (8) tick();
    chk("R12", "old bp gone", {31'b0, (pc > p0 + 32'd16)}, 32'd1);
    chk("R12", "running after reset", {30'b0, st[4:3]}, 32'd0);
    mode = 0;
    do_cmd(8'h02, 32'd0, 1'b0, 32'd0, e, r);

    // R10 trace at one retirement every other cycle
    mode = 2;
    do_cmd(8'h40, 32'd0, 1'b0, 32'd0, e, r);
    chk("R10", "trace enabled", {31'b0, st[12]}, 32'd1);
    p0 = pc; tn = 0; mon_en = 1;
    do_cmd(8'h01, 32'd0, 1'b0, 32'd0, e, r);
    repeat (20) tick();
    do_cmd(8'h02, 32'd0, 1'b0, 32'd0, e, r);
    repeat (8) tick();
    mon_en = 0;
    chk("R10", "enough words, even count", {31'b0, (tn >= 8 && tn % 2 == 0)}, 32'd1);
    chk("R10", "first packet address", tw[0], p0);
    for (int k = 0; k + 1 < tn; k += 2) begin
      chk("R10", "first flag on address", {31'b0, tfl[k]}, 32'd1);
      chk("R10", "no flag on timestamp", {31'b0, tfl[k+1]}, 32'd0);
      if (k >= 2) begin
        chk("R10", "address step", tw[k] - tw[k-2], 32'd4);
        chk("R10", "timestamp step", tw[k+1] - tw[k-1], 32'd2);
      end
    end
    chk("R11", "no loss at half rate", {31'b0, st[13]}, 32'd0);

    // R11 overrun at full rate
    mode = 1;
    do_cmd(8'h01, 32'd0, 1'b0, 32'd0, e, r);
    repeat (10) tick();
    mode = 0;
    do_cmd(8'h02, 32'd0, 1'b0, 32'd0, e, r);
    chk("R11", "lost set", {31'b0, st[13]}, 32'd1);
    repeat (6) tick();
    chk("R11", "lost sticky", {31'b0, st[13]}, 32'd1);
    do_cmd(8'h40, 32'd0, 1'b0, 32'd0, e, r);
    chk("R11", "lost cleared by trace on", {31'b0, st[13]}, 32'd0);

    // R10 trace off gives no packets
    do_cmd(8'h41, 32'd0, 1'b0, 32'd0, e, r);
    chk("R10", "trace disabled", {31'b0, st[12]}, 32'd0);
    repeat (6) tick();
    tn = 0; mon_en = 1; mode = 1;
    do_cmd(8'h01, 32'd0, 1'b0, 32'd0, e, r);
    repeat (10) tick();
    mode = 0;
    do_cmd(8'h02, 32'd0, 1'b0, 32'd0, e, r);
    mon_en = 0;
    chk("R10", "no words with trace off", 32'(tn), 32'd0);

    summary();
  end
endmodule